// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

The block collects up to eight interrupt sources and drives a single interrupt line toward a processor. Software talks to it through a byte-wide port with two addresses. Address 0 takes commands and returns a selectable status byte. Address 1 holds the mask. A rising edge on a source input latches a pending request. The output is raised whenever a pending request is not masked.

An initialization sequence is started by a command byte with bit 4 set. Three data writes then follow. The first of them latches the interrupt vector base, and the other two are accepted and discarded. Other command bytes do one of four things: choose what address 0 returns, retire in-service interrupts (all of them or one chosen one), do nothing, or set a sticky error flag. A test strobe can mark a source as both requested and in service, so that the retire commands can be exercised.

Top module: `pic_ctrl`

## Requirements
- R1: Reset clears the request, in-service and mask registers, the read selection and the initialization step. After reset irq_o and err_o are 0, a read of either address returns 0x00, and vec_base_o is 0x00 (0x08 when SECONDARY is 1).
- R2: A 0-to-1 change of irq_lines_i[n] sets request bit n at the next clock. A line that stays high sets the bit only once. raise_i sets both request and in-service bit raise_idx_i at the next clock.
- R3: irq_o is 1 exactly when some request bit is set whose mask bit is 0. It follows every register change without an added cycle.
- R4: Outside initialization, a write to address 1 loads the mask. A read of address 1 always returns the mask.
- R5: A write to address 0 with bit 4 set starts initialization. The next three writes to address 1 are init words. The first sets vec_base_o to the data with bits 2:0 cleared. The second and third are discarded. None of the three changes the mask, and the fourth write to address 1 loads the mask again.
- R6: A write to address 0 with bit 4 clear ends any initialization in progress. The next write to address 1 loads the mask.
- R7: Command 0x0A makes address 0 read the request register, 0x0B the in-service register, and 0x0C the poll byte. The choice holds until another of these three commands is written.
- R8: The poll byte, which is also what address 0 returns before any selection, is 0x80 OR the index of the lowest-numbered set request bit. It is 0x00 when no request is set.
- R9: Command 0x20 clears every request bit that is set in in-service, then clears in-service entirely.
- R10: Commands 0x21-0x27, 0x60-0x67 and 0xE0-0xE7 clear request bit n and in-service bit n, where n is bits 2:0 of the command.
- R11: Commands 0x68 and 0xC0-0xC7 change no state. Any other command with bit 4 clear that is not named in R7, R9 or R10 sets err_o, which stays 1 until reset.
- R12: When a set (from an edge or from raise_i) and a clear from a retire command hit the same bit in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 1 | Register address: 0 command/status, 1 mask/init data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_lines_i | input | 8 | Edge-sensitive interrupt sources |
| raise_i | input | 1 | Test strobe: set request and in-service bit |
| raise_idx_i | input | 3 | Bit index for raise_i |
| irq_o | output | 1 | Interrupt output to the processor |
| err_o | output | 1 | Sticky flag for an unknown command |
| vec_base_o | output | 8 | Vector base, bits 2:0 always zero |

## Verification
Single sources arrive on the edge inputs and on the raise strobe. A line held high after its request is retired shows that only edges count. Mixed sets of pending bits, such as 0x46 and 0x92, test the lowest-index poll encoding, and they also show how the all-retire command differs from the single-bit one: request bits that are not in service must survive an all-retire. Mask patterns that cover or uncover the only pending bit show whether the output follows the mask. Init sequences run to completion and are also cut short, which separates init words from mask writes. A raise that lands in the same cycle as a retire tells a set-wins ordering apart from a clear-wins one.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_LINES = DATA_W;
  localparam int unsigned IDX_W     = $clog2(NUM_LINES);
  localparam int unsigned BASE_W    = DATA_W - IDX_W;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_IRR  = 2'd1,
    RSEL_ISR  = 2'd2,
    RSEL_POLL = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_e;

  typedef struct packed {
    logic             init_start;
    logic             set_sel;
    rsel_e            sel;
    logic             eoi_all;
    logic             eoi_one;
    logic [IDX_W-1:0] eoi_idx;
    logic             bad;
  } cmd_t;
endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
(
  input  logic [DATA_W-1:0] cmd_i,
  output cmd_t              dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.sel     = RSEL_NONE;
    dec_o.eoi_idx = cmd_i[IDX_W-1:0];
    if (cmd_i[4]) begin
      dec_o.init_start = 1'b1;
    end else begin
      casez (cmd_i)
        8'h0A: begin dec_o.set_sel = 1'b1; dec_o.sel = RSEL_IRR;  end
        8'h0B: begin dec_o.set_sel = 1'b1; dec_o.sel = RSEL_ISR;  end
        8'h0C: begin dec_o.set_sel = 1'b1; dec_o.sel = RSEL_POLL; end
        8'h20:        dec_o.eoi_all = 1'b1;
        8'b0010_0???: dec_o.eoi_one = 1'b1;
        8'b0110_0???: dec_o.eoi_one = 1'b1;
        8'b1110_0???: dec_o.eoi_one = 1'b1;
        8'h68:        ;  // accepted, no effect
        8'b1100_0???: ;  // accepted, no effect
        default:      dec_o.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              start_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] base_o
);
  localparam logic [BASE_W-1:0] BASE_RST = SECONDARY ? BASE_W'(1) : '0;

  init_e             step_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= INIT_IDLE;
      base_q <= BASE_RST;
    end else if (wr_cmd_i) begin
      step_q <= start_i ? INIT_BASE : INIT_IDLE;
    end else if (wr_data_i) begin
      unique case (step_q)
        INIT_BASE: begin
          base_q <= data_i[DATA_W-1:IDX_W];
          step_q <= INIT_CASC;
        end
        INIT_CASC: step_q <= INIT_MODE;
        INIT_MODE: step_q <= INIT_IDLE;
        default:   step_q <= INIT_IDLE;
      endcase
    end
  end

  assign busy_o = (step_q != INIT_IDLE);
  assign base_o = {base_q, {IDX_W{1'b0}}};
endmodule

// File: rtl/pic_lowest.sv
module pic_lowest
  import pic_pkg::*;
(
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 raise_i,
  input  logic [IDX_W-1:0]     raise_idx_i,
  output logic                 irq_o,
  output logic                 err_o,
  output logic [DATA_W-1:0]    vec_base_o
);
  logic [NUM_LINES-1:0] irr_q, isr_q, imr_q, lines_q;
  rsel_e                sel_q;
  logic                 err_q;
  logic                 init_busy;
  logic                 wr_cmd, wr_dat;
  cmd_t                 cmd;
  logic [NUM_LINES-1:0] edge_set, raise_set, clr_irr, clr_isr, one_hot;
  logic                 poll_any;
  logic [IDX_W-1:0]     poll_idx;
  logic [DATA_W-1:0]    poll_byte;

  assign wr_cmd = wr_en_i & ~addr_i;
  assign wr_dat = wr_en_i & addr_i;

  pic_cmd_dec u_dec (
    .cmd_i (wdata_i),
    .dec_o (cmd)
  );

  pic_init_seq #(.SECONDARY(SECONDARY)) u_init (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cmd_i  (wr_cmd),
    .start_i   (cmd.init_start),
    .wr_data_i (wr_dat),
    .data_i    (wdata_i),
    .busy_o    (init_busy),
    .base_o    (vec_base_o)
  );

  pic_lowest u_low (
    .req_i (irr_q),
    .any_o (poll_any),
    .idx_o (poll_idx)
  );

  assign edge_set  = irq_lines_i & ~lines_q;
  assign raise_set = raise_i ? (NUM_LINES'(1) << raise_idx_i) : '0;
  assign one_hot   = NUM_LINES'(1) << cmd.eoi_idx;

  always_comb begin
    clr_irr = '0;
    clr_isr = '0;
    if (wr_cmd && cmd.eoi_all) begin
      clr_irr = isr_q;
      clr_isr = '1;
    end else if (wr_cmd && cmd.eoi_one) begin
      clr_irr = one_hot;
      clr_isr = one_hot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      lines_q <= '0;
      sel_q   <= RSEL_NONE;
      err_q   <= 1'b0;
    end else begin
      // sets are applied after clears: a same-cycle set wins
      irr_q   <= (irr_q & ~clr_irr) | edge_set | raise_set;
      isr_q   <= (isr_q & ~clr_isr) | raise_set;
      lines_q <= irq_lines_i;
      if (wr_dat && !init_busy) imr_q <= wdata_i;
      if (wr_cmd && cmd.set_sel) sel_q <= cmd.sel;
      if (wr_cmd && cmd.bad)     err_q <= 1'b1;
    end
  end

  assign poll_byte = poll_any ? {1'b1, {(DATA_W-1-IDX_W){1'b0}}, poll_idx} : '0;

  always_comb begin
    if (addr_i) begin
      rdata_o = imr_q;
    end else begin
      unique case (sel_q)
        RSEL_IRR: rdata_o = irr_q;
        RSEL_ISR: rdata_o = isr_q;
        default:  rdata_o = poll_byte;
      endcase
    end
  end

  assign irq_o = |(irr_q & ~imr_q);
  assign err_o = err_q;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
  import pic_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] irq_lines_i,
  input logic                 raise_i,
  input logic [IDX_W-1:0]     raise_idx_i,
  input logic                 irq_o,
  input logic                 err_o,
  input logic [NUM_LINES-1:0] irr_q,
  input logic [NUM_LINES-1:0] isr_q,
  input logic [NUM_LINES-1:0] imr_q,
  input logic [1:0]           sel_q,
  input logic                 init_busy
);
  logic spec_eoi;
  assign spec_eoi = (wdata_i[7:3] == 5'b00100 && wdata_i[2:0] != 3'd0) ||
                    (wdata_i[7:3] == 5'b01100) || (wdata_i[7:3] == 5'b11100);

  AST_MASK_BLOCKS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '1) |-> !irq_o);  // R3

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && !init_busy) |=> (imr_q == $past(wdata_i)));  // R4

  AST_INIT_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && init_busy) |=> $stable(imr_q));  // R5

  AST_POLL_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i && (sel_q == 2'd0 || sel_q == 2'd3)) |->
      (rdata_o[6:3] == 4'd0 && rdata_o[7] == (irr_q != '0)));  // R8

  AST_EOI_ALL_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i == 8'h20 && !raise_i) |=> (isr_q == '0));  // R9

  AST_EOI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && spec_eoi && !raise_i && irq_lines_i == '0) |=>
      (!isr_q[$past(wdata_i[2:0])] && !irr_q[$past(wdata_i[2:0])]));  // R10

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);  // R11

  AST_RAISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> (isr_q[$past(raise_idx_i)] && irr_q[$past(raise_idx_i)]));  // R12
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_lines_i (irq_lines_i),
  .raise_i     (raise_i),
  .raise_idx_i (raise_idx_i),
  .irq_o       (irq_o),
  .err_o       (err_o),
  .irr_q       (irr_q),
  .isr_q       (isr_q),
  .imr_q       (imr_q),
  .sel_q       (sel_q),
  .init_busy   (init_busy)
);

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, addr = 1'b0, raise = 1'b0;
  logic [7:0] wdata = 8'h00, lines = 8'h00;
  logic [2:0] ridx = 3'd0;
  logic [7:0] rdata, vbase;
  logic       irq, err;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pic_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_lines_i(lines), .raise_i(raise), .raise_idx_i(ridx),
    .irq_o(irq), .err_o(err), .vec_base_o(vbase)
  );

  // behavioural reference model
  logic [7:0] m_irr, m_isr, m_imr, m_prev, m_base;
  int         m_sel, m_step;
  bit         m_err;

  function automatic logic [7:0] poll_of(input logic [7:0] r);
    for (int i = 7; i >= 0; i--) if (r[i]) poll_of = 8'h80 | 8'(i);
    if (r == 8'h00) poll_of = 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_base = 0;
      m_sel = 0; m_step = 0; m_err = 0;
    end else begin
      logic [7:0] ci, cs, st, rs;
      int d;
      ci = 0; cs = 0;
      rs = raise ? (8'h01 << ridx) : 8'h00;
      st = (lines & ~m_prev) | rs;
      d  = int'(wdata);
      if (wr && !addr) begin
        if (wdata[4]) m_step = 1;
        else begin
          m_step = 0;
          if (d == 'h0A) m_sel = 1;
          else if (d == 'h0B) m_sel = 2;
          else if (d == 'h0C) m_sel = 3;
          else if (d == 'h20) begin ci = m_isr; cs = 8'hFF; end
          else if ((d >= 'h21 && d <= 'h27) || (d >= 'h60 && d <= 'h67) ||
                   (d >= 'hE0 && d <= 'hE7)) begin
            ci = 8'h01 << (d % 8); cs = ci;
          end
          else if (d == 'h68 || (d >= 'hC0 && d <= 'hC7)) ;
          else m_err = 1;
        end
      end else if (wr && addr) begin
        if (m_step == 1) begin m_base = wdata & 8'hF8; m_step = 2; end
        else if (m_step == 2) m_step = 3;
        else if (m_step == 3) m_step = 0;
        else m_imr = wdata;
      end
      m_irr  = (m_irr & ~ci) | st;
      m_isr  = (m_isr & ~cs) | rs;
      m_prev = lines;
    end
  end

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] er;
      er = addr ? m_imr : (m_sel == 1 ? m_irr : (m_sel == 2 ? m_isr : poll_of(m_irr)));
      check8(cur_req, "rdata", rdata, er);
      check8("R3", "irq", {7'd0, irq}, {7'd0, |(m_irr & ~m_imr)});
      check8("R11", "err", {7'd0, err}, {7'd0, m_err});
      check8("R5", "vec_base", vbase, m_base);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_b(input logic a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic raise_b(input logic [2:0] n);
    raise = 1'b1; ridx = n;
    step();
    raise = 1'b0;
  endtask

  task automatic rd(input logic a);
    addr = a; #0.5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    cur_req = "R1";
    rd(1'b0); check8("R1", "poll after reset", rdata, 8'h00);
    rd(1'b1); check8("R1", "mask after reset", rdata, 8'h00);
    check8("R1", "irq/err after reset", {6'd0, irq, err}, 8'h00);
    check8("R1", "vec base after reset", vbase, 8'h00);

    cur_req = "R2";
    rd(1'b0);
    lines = 8'h20; step();
    check8("R2", "edge sets bit 5, irq", {7'd0, irq}, 8'h01);
    check8("R8", "poll lowest 5", rdata, 8'h85);
    wr_b(1'b0, 8'h25); rd(1'b0);
    check8("R2", "held line does not re-set", rdata, 8'h00);
    lines = 8'h00; step();

    cur_req = "R12";
    wr_b(1'b0, 8'h0B);
    raise_b(3'd3); rd(1'b0);
    check8("R2", "raise sets isr bit 3", rdata, 8'h08);
    raise = 1'b1; ridx = 3'd3; wr = 1'b1; addr = 1'b0; wdata = 8'h20;
    step();
    raise = 1'b0; wr = 1'b0;
    check8("R12", "set wins over eoi", rdata, 8'h08);
    wr_b(1'b0, 8'h0A); rd(1'b0);
    check8("R7", "irr select", rdata, 8'h08);

    cur_req = "R4";
    wr_b(1'b1, 8'hF0); rd(1'b1);
    check8("R4", "mask readback", rdata, 8'hF0);
    check8("R3", "unmasked pending", {7'd0, irq}, 8'h01);
    wr_b(1'b1, 8'h08);
    check8("R3", "masked pending", {7'd0, irq}, 8'h00);
    rd(1'b0);
    check8("R7", "irr select persists", rdata, 8'h08);
    wr_b(1'b0, 8'h20); wr_b(1'b1, 8'h00);

    cur_req = "R9";
    raise_b(3'd6); raise_b(3'd2);
    lines = 8'h02; step(); lines = 8'h00; step();
    wr_b(1'b0, 8'h0C); rd(1'b0);
    check8("R8", "poll lowest of 0x46", rdata, 8'h81);
    wr_b(1'b0, 8'h20); wr_b(1'b0, 8'h0A); rd(1'b0);
    check8("R9", "non-serviced request kept", rdata, 8'h02);
    wr_b(1'b0, 8'h0B); rd(1'b0);
    check8("R9", "isr cleared", rdata, 8'h00);

    cur_req = "R10";
    raise_b(3'd4); raise_b(3'd7);
    wr_b(1'b0, 8'hE4); rd(1'b0);
    check8("R10", "0xE4 clears bit 4", rdata, 8'h80);
    wr_b(1'b0, 8'h67); rd(1'b0);
    check8("R10", "0x67 clears bit 7", rdata, 8'h00);
    wr_b(1'b0, 8'h0A); wr_b(1'b0, 8'h21); rd(1'b0);
    check8("R10", "0x21 clears irr bit 1", rdata, 8'h00);

    cur_req = "R5";
    wr_b(1'b0, 8'h11); wr_b(1'b1, 8'hAD);
    check8("R5", "vec base latched", vbase, 8'hA8);
    wr_b(1'b1, 8'h04); wr_b(1'b1, 8'h01); rd(1'b1);
    check8("R5", "init words skip mask", rdata, 8'h00);
    wr_b(1'b1, 8'h3C); rd(1'b1);
    check8("R5", "mask after init", rdata, 8'h3C);

    cur_req = "R6";
    wr_b(1'b0, 8'h13); wr_b(1'b0, 8'h0B); wr_b(1'b1, 8'h77); rd(1'b1);
    check8("R6", "abort then mask", rdata, 8'h77);
    check8("R6", "base kept on abort", vbase, 8'hA8);

    cur_req = "R11";
    wr_b(1'b0, 8'h68); wr_b(1'b0, 8'hC5); rd(1'b1);
    check8("R11", "no-op keeps mask", rdata, 8'h77);
    check8("R11", "no-op no error", {7'd0, err}, 8'h00);
    wr_b(1'b0, 8'h40);
    check8("R11", "unknown sets error", {7'd0, err}, 8'h01);
    wr_b(1'b0, 8'h0A);
    check8("R11", "error sticky", {7'd0, err}, 8'h01);

    step(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule